// File: doc/BRIEF.md
# I2C Master Byte DMA Engine

This block lets an I2C master controller move whole messages between system memory and its byte shifter without the processor touching each byte. Software loads a buffer base address and a byte count through a small register port. It then writes the command register with a transmit-DMA or a receive-DMA enable bit. On transmit, the engine reads one byte at a time from memory and offers it to the I2C byte sender. On receive, it takes each byte from the I2C byte receiver and writes it to memory.

After each byte the address moves up by one and the count moves down by one. The enable bit clears by itself when the count runs out, and a one-cycle `done` pulse tells the surrounding controller to raise its interrupt. A parameter removes DMA support altogether. The engine then refuses DMA commands and its two DMA registers read as all ones.

Top module: `i2c_byte_dma`

## Requirements
- R1: After reset the address register, the length register and the command register read zero, and `mem_req`, `tx_valid`, `rx_ready` and `done` are low.
- R2: The address register is at offset 0x24. A write stores the value with bits 1:0 forced to zero, and a read returns the stored value.
- R3: The length register is at offset 0x28 and keeps only bits 11:0 of a write. A write whose low 12 bits are zero gives a one-cycle `len_zero` pulse. Other writes give none.
- R4: The command register is at offset 0x14: bit 0 start, bit 1 master-transmit, bit 2 master-receive, bit 8 transmit-DMA enable, bit 9 receive-DMA enable. Register writes made while a transfer is pending or running are ignored.
- R5: Each byte moved adds one to the address register and subtracts one from the length register. The length never wraps below zero.
- R6: A transmit-DMA transfer sends the bytes stored at address, address+1, … in that order on `tx_data`, until the length reaches zero. It then clears transmit-DMA enable and master-transmit.
- R7: With the start bit set, the first byte fetched is flagged with `tx_first` as the slave address byte. That byte uses one count of the length, and the start bit clears once it is sent. No other byte is flagged.
- R8: A send that reports `tx_nak` ends the transmit transfer early and clears transmit-DMA enable. Master-transmit stays set while the remaining length is nonzero.
- R9: A receive-DMA transfer writes each received byte to consecutive addresses until the length reaches zero. It then clears receive-DMA enable and master-receive.
- R10: A memory response with `mem_err` aborts the transfer at once. The DMA enable bit stays set, and the address and length are left at the failing byte.
- R11: Setting a DMA enable bit while the length is zero ends the transfer without any memory access.
- R12: Every completed or aborted transfer produces exactly one `done` pulse, one cycle wide.
- R13: With DMA_EN=0, offsets 0x24 and 0x28 read 0xFFFFFFFF. A command write that sets either DMA enable bit is rejected whole. Command writes without those bits are accepted.
- R14: Once raised, `mem_req` stays high with a stable address until `mem_ack`. Once raised, `tx_valid` stays high with stable data until `tx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid with `mem_ack` |
| mem_ack | input | 1 | Request completed this cycle |
| mem_err | input | 1 | Completed request failed, valid with `mem_ack` |
| tx_valid | output | 1 | Byte offered to the I2C sender |
| tx_data | output | 8 | Byte to send |
| tx_first | output | 1 | Offered byte is the slave address after a start |
| tx_ready | input | 1 | Sender took the byte this cycle |
| tx_nak | input | 1 | The taken byte was not acknowledged |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Engine accepts a received byte |
| done | output | 1 | One-cycle end-of-transfer pulse |
| len_zero | output | 1 | One-cycle pulse on a zero-length write |

## Verification
The hold properties assume that `mem_ack` comes only while `mem_req` is high, and `tx_ready` and `rx_valid` only while `tx_valid` or `rx_ready` is offered. They also assume each of these responses lasts exactly one cycle. The bench responders sample the requests half a cycle after each edge and pulse their response for a single cycle, with random wait states between. They never answer two cycles in a row. Register writes are made only when the engine is idle, except for one deliberate write during a transfer that checks it is ignored. Transfer bases stay inside the modelled memory window, so every error is a deliberate, injected one.

// File: rtl/i2c_dma_pkg.sv
`timescale 1ns/1ps
package i2c_dma_pkg;
    localparam logic [7:0] OFS_CMD  = 8'h14;
    localparam logic [7:0] OFS_ADDR = 8'h24;
    localparam logic [7:0] OFS_LEN  = 8'h28;

    localparam int B_START = 0;
    localparam int B_MTX   = 1;
    localparam int B_MRX   = 2;
    localparam int B_TXEN  = 8;
    localparam int B_RXEN  = 9;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_SEND,
        S_RECV,
        S_STORE
    } dma_st_e;

    typedef struct packed {
        logic start;
        logic mtx;
        logic mrx;
        logic txen;
        logic rxen;
    } cmd_t;
endpackage

// File: rtl/i2c_dma_regs.sv
`timescale 1ns/1ps
module i2c_dma_regs
    import i2c_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 12,
    parameter bit DMA_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       wdata,
    input  logic              engine_busy,
    input  logic              step,
    input  logic              clr_tx,
    input  logic              clr_rx,
    input  logic              clr_start,
    output logic [31:0]       rdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LEN_W-1:0]  len_q,
    output cmd_t              cmd_q,
    output logic              go_q,
    output logic              len_zero_q
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        cmd_t              cmd;
        logic              go;
        logic              len_zero;
    } regs_t;

    regs_t r_d, r_q;
    logic  busy;
    logic  wr_ok;
    logic  cmd_has_dma;
    logic  wdata_unused;
    logic [31:0] dma_addr_rd, dma_len_rd;

    assign busy         = engine_busy | r_q.go;
    assign wr_ok        = wr_en & ~busy;
    assign cmd_has_dma  = wdata[B_TXEN] | wdata[B_RXEN];
    assign wdata_unused = ^wdata;

    always_comb begin
        r_d          = r_q;
        r_d.go       = 1'b0;
        r_d.len_zero = 1'b0;
        if (step) begin
            r_d.addr = r_q.addr + ADDR_W'(1);
            r_d.len  = r_q.len - LEN_W'(1);
        end
        if (clr_start) r_d.cmd.start = 1'b0;
        if (clr_tx) begin
            r_d.cmd.txen = 1'b0;
            if (r_d.len == '0) r_d.cmd.mtx = 1'b0;
        end
        if (clr_rx) begin
            r_d.cmd.rxen = 1'b0;
            r_d.cmd.mrx  = 1'b0;
        end
        if (wr_ok) begin
            case (reg_addr)
                OFS_ADDR: if (DMA_EN) r_d.addr = {wdata[ADDR_W-1:2], 2'b00};
                OFS_LEN: if (DMA_EN) begin
                    r_d.len      = wdata[LEN_W-1:0];
                    r_d.len_zero = (wdata[LEN_W-1:0] == '0);
                end
                OFS_CMD: if (DMA_EN || !cmd_has_dma) begin
                    r_d.cmd.start = wdata[B_START];
                    r_d.cmd.mtx   = wdata[B_MTX];
                    r_d.cmd.mrx   = wdata[B_MRX];
                    r_d.cmd.txen  = wdata[B_TXEN];
                    r_d.cmd.rxen  = wdata[B_RXEN];
                    r_d.go        = cmd_has_dma;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    generate
        if (DMA_EN) begin : g_dma_rd
            assign dma_addr_rd = 32'(r_q.addr);
            assign dma_len_rd  = 32'(r_q.len);
        end else begin : g_no_dma_rd
            assign dma_addr_rd = '1;
            assign dma_len_rd  = '1;
        end
    endgenerate

    always_comb begin
        rdata = '0;
        case (reg_addr)
            OFS_CMD: begin
                rdata[B_START] = r_q.cmd.start;
                rdata[B_MTX]   = r_q.cmd.mtx;
                rdata[B_MRX]   = r_q.cmd.mrx;
                rdata[B_TXEN]  = r_q.cmd.txen;
                rdata[B_RXEN]  = r_q.cmd.rxen;
            end
            OFS_ADDR: rdata = dma_addr_rd;
            OFS_LEN:  rdata = dma_len_rd;
            default:  rdata = '0;
        endcase
    end

    assign addr_q     = r_q.addr;
    assign len_q      = r_q.len;
    assign cmd_q      = r_q.cmd;
    assign go_q       = r_q.go;
    assign len_zero_q = r_q.len_zero;

    // R5: the engine only steps while bytes remain
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (r_q.len != '0));

    // R2: an accepted address write always lands aligned
    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && reg_addr == OFS_ADDR && DMA_EN) |=> (r_q.addr[1:0] == 2'b00));
endmodule

// File: rtl/i2c_dma_fsm.sv
`timescale 1ns/1ps
module i2c_dma_fsm
    import i2c_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  cmd_t              cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic              tx_ready,
    input  logic              tx_nak,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_first,
    output logic              rx_ready,
    output logic              step,
    output logic              clr_tx,
    output logic              clr_rx,
    output logic              clr_start,
    output logic              busy,
    output logic              done
);
    typedef struct packed {
        dma_st_e    st;
        logic [7:0] byte_v;
        logic       done;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d       = f_q;
        f_d.done  = 1'b0;
        step      = 1'b0;
        clr_tx    = 1'b0;
        clr_rx    = 1'b0;
        clr_start = 1'b0;
        case (f_q.st)
            S_IDLE: if (go) begin
                if (cmd.txen) begin
                    if (len == '0) begin
                        clr_tx   = 1'b1;
                        f_d.done = 1'b1;
                    end else f_d.st = S_FETCH;
                end else if (cmd.rxen) begin
                    if (len == '0) begin
                        clr_rx   = 1'b1;
                        f_d.done = 1'b1;
                    end else f_d.st = S_RECV;
                end
            end
            S_FETCH: if (mem_ack) begin
                if (mem_err) begin
                    f_d.done = 1'b1;
                    f_d.st   = S_IDLE;
                end else begin
                    f_d.byte_v = mem_rdata;
                    step       = 1'b1;
                    f_d.st     = S_SEND;
                end
            end
            S_SEND: if (tx_ready) begin
                clr_start = 1'b1;
                if (tx_nak || len == '0) begin
                    clr_tx   = 1'b1;
                    f_d.done = 1'b1;
                    f_d.st   = S_IDLE;
                end else f_d.st = S_FETCH;
            end
            S_RECV: if (rx_valid) begin
                f_d.byte_v = rx_data;
                f_d.st     = S_STORE;
            end
            S_STORE: if (mem_ack) begin
                if (mem_err) begin
                    f_d.done = 1'b1;
                    f_d.st   = S_IDLE;
                end else begin
                    step = 1'b1;
                    if (len == LEN_W'(1)) begin
                        clr_rx   = 1'b1;
                        f_d.done = 1'b1;
                        f_d.st   = S_IDLE;
                    end else f_d.st = S_RECV;
                end
            end
            default: f_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: S_IDLE, byte_v: 8'h00, done: 1'b0};
        else        f_q <= f_d;
    end

    assign mem_req   = (f_q.st == S_FETCH) || (f_q.st == S_STORE);
    assign mem_we    = (f_q.st == S_STORE);
    assign mem_addr  = addr;
    assign mem_wdata = f_q.byte_v;
    assign tx_valid  = (f_q.st == S_SEND);
    assign tx_data   = f_q.byte_v;
    assign tx_first  = (f_q.st == S_SEND) && cmd.start;
    assign rx_ready  = (f_q.st == S_RECV);
    assign busy      = (f_q.st != S_IDLE);
    assign done      = f_q.done;

    // R12: end-of-transfer indication is a single-cycle pulse
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R14: a memory request is held with a stable address until acknowledged
    a_r14_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R14: an offered transmit byte is held until taken
    a_r14_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R10: a failed receive store leaves the receive enable set
    a_r10_rx_abort_keeps_en: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == S_STORE && mem_ack && mem_err) |=> cmd.rxen);
endmodule

// File: rtl/i2c_byte_dma.sv
`timescale 1ns/1ps
module i2c_byte_dma
    import i2c_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 12,
    parameter bit DMA_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_first,
    input  logic              tx_ready,
    input  logic              tx_nak,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              done,
    output logic              len_zero
);
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    cmd_t              cmd_q;
    logic              go_q, step, clr_tx, clr_rx, clr_start, eng_busy;

    i2c_dma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DMA_EN(DMA_EN)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr),
        .reg_addr    (reg_addr),
        .wdata       (reg_wdata),
        .engine_busy (eng_busy),
        .step        (step),
        .clr_tx      (clr_tx),
        .clr_rx      (clr_rx),
        .clr_start   (clr_start),
        .rdata       (reg_rdata),
        .addr_q      (addr_q),
        .len_q       (len_q),
        .cmd_q       (cmd_q),
        .go_q        (go_q),
        .len_zero_q  (len_zero)
    );

    i2c_dma_fsm #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go_q),
        .cmd       (cmd_q),
        .addr      (addr_q),
        .len       (len_q),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .mem_err   (mem_err),
        .tx_ready  (tx_ready),
        .tx_nak    (tx_nak),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_first  (tx_first),
        .rx_ready  (rx_ready),
        .step      (step),
        .clr_tx    (clr_tx),
        .clr_rx    (clr_rx),
        .clr_start (clr_start),
        .busy      (eng_busy),
        .done      (done)
    );
endmodule

// File: tb/i2c_byte_dma_tb_top.sv
`timescale 1ns/1ps
module i2c_byte_dma_tb_top;
    localparam logic [7:0] A_CMD = 8'h14, A_ADR = 8'h24, A_LEN = 8'h28;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        reg_wr = 0, nd_wr = 0;
    logic [7:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata, nd_rdata;
    logic        mem_req, mem_we, mem_ack = 0, mem_err = 0;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata = 0;
    logic        tx_valid, tx_first, tx_ready = 0, tx_nak = 0;
    logic [7:0]  tx_data;
    logic        rx_valid = 0, rx_ready;
    logic [7:0]  rx_data = 0;
    logic        done, len_zero;

    logic        nd_req, nd_we, nd_txv, nd_txf, nd_rxr, nd_done, nd_lz;
    logic [31:0] nd_maddr;
    logic [7:0]  nd_wd, nd_txd;

    i2c_byte_dma dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_first(tx_first),
        .tx_ready(tx_ready), .tx_nak(tx_nak), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_ready(rx_ready), .done(done), .len_zero(len_zero)
    );

    i2c_byte_dma #(.DMA_EN(1'b0)) dut_nd (
        .clk(clk), .rst_n(rst_n), .reg_wr(nd_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(nd_rdata), .mem_req(nd_req),
        .mem_we(nd_we), .mem_addr(nd_maddr), .mem_wdata(nd_wd),
        .mem_rdata(8'h00), .mem_ack(1'b0), .mem_err(1'b0),
        .tx_valid(nd_txv), .tx_data(nd_txd), .tx_first(nd_txf),
        .tx_ready(1'b0), .tx_nak(1'b0), .rx_valid(1'b0),
        .rx_data(8'h00), .rx_ready(nd_rxr), .done(nd_done), .len_zero(nd_lz)
    );

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    logic [7:0]  mem [0:1023];
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    int ndone = 0, nlz = 0, nacc = 0, hold_viol = 0, nd_active = 0;
    int nsent = 0, nrecv = 0, nak_at = -1;
    int mwait = 0, twait = 0, rwait = 0;
    logic [7:0] sentb [0:63];
    logic       firstf [0:63];
    logic [7:0] rx_seed = 8'h11;
    logic p_req = 0, p_ack = 0, p_tv = 0, p_tr = 0, p_rv = 0;
    logic [31:0] p_addr = 0;
    logic [7:0]  p_td = 0;

    function automatic logic [7:0] rx_pat(int i);
        return 8'(i * 37) + rx_seed;
    endfunction

    always @(posedge clk) begin
        if (done) ndone++;
        if (len_zero) nlz++;
        if (nd_req || nd_txv || nd_rxr || nd_done) nd_active++;
    end

    // memory responder plus R14 hold monitor
    always @(negedge clk) begin
        if (p_req && !p_ack && (!mem_req || mem_addr != p_addr)) hold_viol++;
        if (p_tv && !p_tr && (!tx_valid || tx_data != p_td)) hold_viol++;
        p_req = mem_req; p_addr = mem_addr; p_tv = tx_valid; p_td = tx_data;
        mem_ack = 0; mem_err = 0;
        if (mem_req && !p_ack) begin
            if (mwait == 0) begin
                mem_ack = 1; nacc++;
                if (mem_addr == err_addr) mem_err = 1;
                else if (mem_we) mem[mem_addr[9:0]] = mem_wdata;
                else mem_rdata = mem[mem_addr[9:0]];
                mwait = int'($urandom % 3);
            end else mwait--;
        end
        p_ack = mem_ack;
        tx_ready = 0; tx_nak = 0;
        if (tx_valid && !p_tr) begin
            if (twait == 0) begin
                tx_ready = 1;
                sentb[nsent[5:0]] = tx_data;
                firstf[nsent[5:0]] = tx_first;
                if (nsent == nak_at) tx_nak = 1;
                nsent++;
                twait = int'($urandom % 3);
            end else twait--;
        end
        p_tr = tx_ready;
        rx_valid = 0;
        if (rx_ready && !p_rv) begin
            if (rwait == 0) begin
                rx_valid = 1;
                rx_data = rx_pat(nrecv);
                nrecv++;
                rwait = int'($urandom % 3);
            end else rwait--;
        end
        p_rv = rx_valid;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit nd);
        @(negedge clk);
        reg_addr = a; reg_wdata = d;
        if (nd) nd_wr = 1; else reg_wr = 1;
        @(negedge clk);
        reg_wr = 0; nd_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, input bit nd, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        d = nd ? nd_rdata : reg_rdata;
    endtask

    task automatic wait_done(input int d0);
        while (ndone == d0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_tx(input int base, input int n, input bit st, input int nk, input int eo);
        int d0, ks, el, bad, badf;
        bit enl;
        logic [31:0] v;
        for (int i = 0; i < n; i++) mem[base + i] = 8'($urandom);
        nak_at = nk; nsent = 0;
        err_addr = (eo >= 0) ? 32'(base + eo) : 32'hFFFF_FFFF;
        wr(A_ADR, 32'(base) | 32'($urandom % 4), 0);
        wr(A_LEN, 32'(n), 0);
        d0 = ndone;
        wr(A_CMD, 32'h102 | 32'(st), 0);
        wait_done(d0);
        if (eo >= 0) begin ks = eo; el = n - eo; enl = 1; end
        else if (nk >= 0 && nk < n) begin ks = nk + 1; el = n - ks; enl = 0; end
        else begin ks = n; el = 0; enl = 0; end
        chk("R6 bytes sent", 32'(nsent), 32'(ks));
        bad = 0; badf = 0;
        for (int i = 0; i < ks; i++) begin
            if (sentb[i] !== mem[base + i]) bad++;
            if (firstf[i] !== ((i == 0) && st)) badf++;
        end
        chk("R6 byte order", 32'(bad), 0);
        chk("R7 first flag", 32'(badf), 0);
        rd(A_ADR, 0, v); chk("R5 tx addr", v, 32'(base + ks));
        rd(A_LEN, 0, v); chk("R5 tx len", v, 32'(el));
        rd(A_CMD, 0, v);
        chk(eo >= 0 ? "R10 tx cmd" : (nk >= 0 ? "R8 tx cmd" : "R6 tx cmd"), v,
            32'(st && ks == 0) | (32'(enl || el != 0) << 1) | (32'(enl) << 8));
        chk("R12 done once", 32'(ndone - d0), 1);
        nak_at = -1;
    endtask

    task automatic run_rx(input int base, input int n, input int eo, input bit poke);
        int d0, k, bad;
        logic [31:0] v;
        for (int i = 0; i < n; i++) mem[base + i] = 8'h00;
        rx_seed = 8'($urandom); nrecv = 0;
        err_addr = (eo >= 0) ? 32'(base + eo) : 32'hFFFF_FFFF;
        wr(A_ADR, 32'(base), 0);
        wr(A_LEN, 32'(n), 0);
        d0 = ndone;
        wr(A_CMD, 32'h204, 0);
        if (poke) wr(A_ADR, 32'h300, 0);
        wait_done(d0);
        k = (eo >= 0) ? eo : n;
        bad = 0;
        for (int i = 0; i < k; i++) if (mem[base + i] !== rx_pat(i)) bad++;
        chk("R9 rx data", 32'(bad), 0);
        rd(A_ADR, 0, v); chk(poke ? "R4 write ignored while busy" : "R5 rx addr", v, 32'(base + k));
        rd(A_LEN, 0, v); chk("R5 rx len", v, 32'(n - k));
        rd(A_CMD, 0, v);
        chk(eo >= 0 ? "R10 rx enable kept" : "R9 rx cmd", v, (eo >= 0) ? 32'h204 : 32'h0);
        chk("R12 done once", 32'(ndone - d0), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int a0, lz0;
        void'($urandom(32'd4242));
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 outputs idle", {28'd0, mem_req, tx_valid, rx_ready, done}, 0);
        rst_n = 1;
        rd(A_ADR, 0, v); chk("R1 addr reset", v, 0);
        rd(A_LEN, 0, v); chk("R1 len reset", v, 0);
        rd(A_CMD, 0, v); chk("R1 cmd reset", v, 0);

        // R2 alignment
        wr(A_ADR, 32'h0000_1237, 0);
        rd(A_ADR, 0, v); chk("R2 addr aligned", v, 32'h0000_1234);
        // R3 masking and zero-length pulse
        lz0 = nlz;
        wr(A_LEN, 32'h0000_F005, 0);
        rd(A_LEN, 0, v); chk("R3 len masked", v, 32'h005);
        chk("R3 no zero pulse", 32'(nlz - lz0), 0);
        wr(A_LEN, 32'h0000_1000, 0);
        rd(A_LEN, 0, v); chk("R3 len zero", v, 0);
        chk("R3 zero pulse", 32'(nlz - lz0), 1);

        // R11 zero length transfer
        a0 = nacc;
        begin
            int d0;
            d0 = ndone;
            wr(A_CMD, 32'h103, 0);
            wait_done(d0);
            chk("R11 no mem access", 32'(nacc - a0), 0);
            rd(A_CMD, 0, v); chk("R11 cmd cleared", v, 32'h1);
            chk("R12 done on empty", 32'(ndone - d0), 1);
        end

        // directed transfers
        run_tx(64, 8, 1, -1, -1);
        run_tx(128, 6, 0, 2, -1);
        run_tx(200, 5, 1, 4, -1);
        run_tx(256, 7, 1, -1, 3);
        run_rx(320, 9, -1, 0);
        run_rx(400, 10, 4, 0);
        run_rx(500, 12, -1, 1);
        run_tx(600, 1, 1, -1, -1);

        // random mix
        for (int it = 0; it < 24; it++) begin
            int n, base, nk, eo;
            n = 1 + int'($urandom % 40);
            base = int'($urandom % 200) * 4;
            nk = -1; eo = -1;
            if ($urandom % 4 == 0) nk = int'($urandom % n);
            else if ($urandom % 4 == 0) eo = int'($urandom % n);
            if ($urandom % 2 == 0) run_tx(base, n, 1'($urandom), nk, eo);
            else run_rx(base, n, eo, 0);
        end
        err_addr = 32'hFFFF_FFFF;
        chk("R14 handshake held", 32'(hold_viol), 0);

        // R13 DMA disabled variant
        wr(A_ADR, 32'h0000_0040, 1);
        rd(A_ADR, 1, v); chk("R13 addr reads ones", v, 32'hFFFF_FFFF);
        rd(A_LEN, 1, v); chk("R13 len reads ones", v, 32'hFFFF_FFFF);
        wr(A_CMD, 32'h102, 1);
        rd(A_CMD, 1, v); chk("R13 dma cmd rejected", v, 0);
        wr(A_CMD, 32'h002, 1);
        rd(A_CMD, 1, v); chk("R13 plain cmd accepted", v, 32'h2);
        repeat (4) @(negedge clk);
        chk("R13 no activity", 32'(nd_active), 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule